// File: doc/BRIEF.md
# Hottest-Zone Fan Control Selector

This block takes a set of fine-resolution temperature readings, applies signed calibration offsets to the two remote-diode inputs, and sorts every reading into one of four thermal zones. The zone map can be rewritten at run time and returns to a fixed assignment after reset. Each zone's temperature is the hottest reading mapped to it, so one zone can gather several sources, for example up to four processor-reported temperatures.

Each fan has a mask of zones that may drive it. For every fan the block outputs the hottest temperature among its masked zones, at full resolution, to feed a stepless PWM duty generator. It also outputs the index of the zone that won, so software can see which zone is controlling each fan. A new set of readings is taken when `sampleEn` is high. The adjusted readings appear one cycle later and the fan results two cycles later.

Top module: `hotzone_fan_sel`

## Requirements
- R1: After reset, `srcReport` is all zeros, every fan's `fanTemp` slice is 0x8000, every `fanZone` slice is 3'b111, and the zone map holds its default.
- R2: The default zone map routes source s to zone s mod 4.
- R3: A cycle with `mapWe` high writes `mapZone` into the map entry for source `mapSel` (an out-of-range `mapSel` is ignored). The new map affects outputs only at the next fan-stage update that `sampleEn` starts.
- R4: Sources 0 and 1 have the signed 8-bit offset from `srcOffset[8*s +: 8]` added, sign-extended and in the same LSB units. The offset changes both `srcReport` and the value used for fan control. All other sources pass through unchanged.
- R5: An offset sum above 0x7FFF gives 0x7FFF, and one below 0x8000 (most negative) gives 0x8000. The sum never wraps.
- R6: A zone's temperature is the signed maximum of all sources mapped to it, with any number of sources per zone. A zone with no sources reads 0x8000.
- R7: Temperatures are signed 16-bit two's complement. Fan f, with mask bits `fanMask[4*f +: 4]` (bit z selects zone z), outputs on `fanTemp[16*f +: 16]` the signed maximum of its selected zones.
- R8: `fanZone[3*f +: 3]` gives the index of the winning zone. When zones tie, the lowest-numbered one is reported.
- R9: A fan with an empty mask outputs 0x8000 and zone code 3'b111.
- R10: `srcReport` updates on the clock edge that samples `sampleEn` high. `fanTemp` and `fanZone` update on the following edge. With no `sampleEn`, all outputs hold.
- R11: Selection uses all 16 bits, so readings that differ only in the LSB are told apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | Capture new readings this cycle |
| srcTemp | input | 96 | Six signed 16-bit source temperatures, source s at [16*s +: 16] |
| srcOffset | input | 16 | Two signed 8-bit offsets for sources 0 and 1 |
| mapWe | input | 1 | Zone-map write strobe |
| mapSel | input | 3 | Source whose map entry is written |
| mapZone | input | 2 | Zone written into the selected entry |
| fanMask | input | 12 | Per-fan 4-bit zone masks |
| srcReport | output | 96 | Offset-adjusted, saturated source readings |
| fanTemp | output | 48 | Per-fan control temperature |
| fanZone | output | 9 | Per-fan controlling zone index, 3'b111 for no zone |

## Verification
The assertions check on every cycle that outputs hold when no sample was taken, that a reported zone index is legal, that an empty mask yields the minimum temperature and the no-zone code, and that a source with no offset is reported unchanged. The values themselves can only be shown by the bench's scenarios: offset arithmetic and saturation, zone aggregation after remapping, signed maximum selection, tie-breaking to the lower zone, and the one-cycle skew between the reported readings and the fan outputs.

// File: rtl/hzsel_pkg.sv
package hzsel_pkg;
  typedef struct packed {
    logic loadSrc;
    logic loadFan;
  } hzStrobe_t;
endpackage

// File: rtl/hzsel_ctrl.sv
module hzsel_ctrl
  import hzsel_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int NUM_ZONE = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sampleEn,
  input  logic                           mapWe,
  input  logic [$clog2(NUM_SRC)-1:0]     mapSel,
  input  logic [$clog2(NUM_ZONE)-1:0]    mapZone,
  output hzStrobe_t                      strobe,
  output logic [NUM_SRC*$clog2(NUM_ZONE)-1:0] zoneMap
);
  localparam int ZONE_W = $clog2(NUM_ZONE);

  logic loadFanQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadFanQ <= 1'b0;
    else       loadFanQ <= sampleEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++)
        zoneMap[s*ZONE_W +: ZONE_W] <= ZONE_W'(s % NUM_ZONE);
    end else if (mapWe && (int'(mapSel) < NUM_SRC)) begin
      zoneMap[mapSel*ZONE_W +: ZONE_W] <= mapZone;
    end
  end

  assign strobe = '{loadSrc: sampleEn, loadFan: loadFanQ};
endmodule

// File: rtl/hzsel_datapath.sv
module hzsel_datapath
  import hzsel_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int NUM_ZONE = 4,
  parameter int NUM_FAN  = 3,
  parameter int TEMP_W   = 16,
  parameter int OFS_W    = 8,
  parameter int NUM_OFS  = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  hzStrobe_t                             strobe,
  input  logic [NUM_SRC*TEMP_W-1:0]             srcTemp,
  input  logic [NUM_OFS*OFS_W-1:0]              srcOffset,
  input  logic [NUM_SRC*$clog2(NUM_ZONE)-1:0]   zoneMap,
  input  logic [NUM_FAN*NUM_ZONE-1:0]           fanMask,
  output logic [NUM_SRC*TEMP_W-1:0]             srcReport,
  output logic [NUM_FAN*TEMP_W-1:0]             fanTemp,
  output logic [NUM_FAN*$clog2(NUM_ZONE+1)-1:0] fanZone
);
  localparam int ZONE_W = $clog2(NUM_ZONE);
  localparam int ZIDX_W = $clog2(NUM_ZONE+1);
  localparam logic [TEMP_W-1:0] T_MIN   = {1'b1, {(TEMP_W-1){1'b0}}};
  localparam logic [TEMP_W-1:0] T_MAX   = {1'b0, {(TEMP_W-1){1'b1}}};
  localparam logic [ZIDX_W-1:0] NO_ZONE = '1;

  logic [TEMP_W-1:0] adjTemp  [NUM_SRC];
  logic [TEMP_W-1:0] srcQ     [NUM_SRC];
  logic [TEMP_W-1:0] zoneTemp [NUM_ZONE];
  logic [TEMP_W-1:0] nextTemp [NUM_FAN];
  logic [ZIDX_W-1:0] nextIdx  [NUM_FAN];
  logic [TEMP_W-1:0] fanTempQ [NUM_FAN];
  logic [ZIDX_W-1:0] fanZoneQ [NUM_FAN];

  // Offset stage: only the first NUM_OFS sources carry a calibration offset
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < NUM_OFS) begin : g_ofs
      logic [TEMP_W:0] sumW;
      assign sumW = {srcTemp[s*TEMP_W+TEMP_W-1], srcTemp[s*TEMP_W +: TEMP_W]}
                  + {{(TEMP_W+1-OFS_W){srcOffset[s*OFS_W+OFS_W-1]}},
                     srcOffset[s*OFS_W +: OFS_W]};
      assign adjTemp[s] = (sumW[TEMP_W] != sumW[TEMP_W-1])
                        ? (sumW[TEMP_W] ? T_MIN : T_MAX)
                        : sumW[TEMP_W-1:0];
    end else begin : g_pass
      assign adjTemp[s] = srcTemp[s*TEMP_W +: TEMP_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               srcQ[s] <= '0;
      else if (strobe.loadSrc) srcQ[s] <= adjTemp[s];
    end

    assign srcReport[s*TEMP_W +: TEMP_W] = srcQ[s];
  end

  // Zone aggregation: signed maximum over the sources mapped to each zone
  always_comb begin
    for (int z = 0; z < NUM_ZONE; z++) begin
      zoneTemp[z] = T_MIN;
      for (int s = 0; s < NUM_SRC; s++) begin
        if ((zoneMap[s*ZONE_W +: ZONE_W] == ZONE_W'(z)) &&
            ($signed(srcQ[s]) > $signed(zoneTemp[z])))
          zoneTemp[z] = srcQ[s];
      end
    end
  end

  // Fan selection: strict compare keeps the lowest zone on a tie
  always_comb begin
    for (int f = 0; f < NUM_FAN; f++) begin
      nextTemp[f] = T_MIN;
      nextIdx[f]  = NO_ZONE;
      for (int z = 0; z < NUM_ZONE; z++) begin
        if (fanMask[f*NUM_ZONE+z] &&
            ((nextIdx[f] == NO_ZONE) ||
             ($signed(zoneTemp[z]) > $signed(nextTemp[f])))) begin
          nextTemp[f] = zoneTemp[z];
          nextIdx[f]  = ZIDX_W'(z);
        end
      end
    end
  end

  for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fanTempQ[f] <= T_MIN;
        fanZoneQ[f] <= NO_ZONE;
      end else if (strobe.loadFan) begin
        fanTempQ[f] <= nextTemp[f];
        fanZoneQ[f] <= nextIdx[f];
      end
    end
    assign fanTemp[f*TEMP_W +: TEMP_W] = fanTempQ[f];
    assign fanZone[f*ZIDX_W +: ZIDX_W] = fanZoneQ[f];
  end
endmodule

// File: rtl/hotzone_fan_sel.sv
module hotzone_fan_sel
  import hzsel_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int NUM_ZONE = 4,
  parameter int NUM_FAN  = 3,
  parameter int TEMP_W   = 16,
  parameter int OFS_W    = 8,
  parameter int NUM_OFS  = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  sampleEn,
  input  logic [NUM_SRC*TEMP_W-1:0]             srcTemp,
  input  logic [NUM_OFS*OFS_W-1:0]              srcOffset,
  input  logic                                  mapWe,
  input  logic [$clog2(NUM_SRC)-1:0]            mapSel,
  input  logic [$clog2(NUM_ZONE)-1:0]           mapZone,
  input  logic [NUM_FAN*NUM_ZONE-1:0]           fanMask,
  output logic [NUM_SRC*TEMP_W-1:0]             srcReport,
  output logic [NUM_FAN*TEMP_W-1:0]             fanTemp,
  output logic [NUM_FAN*$clog2(NUM_ZONE+1)-1:0] fanZone
);
  localparam int ZONE_W = $clog2(NUM_ZONE);

  hzStrobe_t                  strobe;
  logic [NUM_SRC*ZONE_W-1:0]  zoneMap;

  hzsel_ctrl #(.NUM_SRC(NUM_SRC), .NUM_ZONE(NUM_ZONE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .mapWe(mapWe), .mapSel(mapSel), .mapZone(mapZone),
    .strobe(strobe), .zoneMap(zoneMap)
  );

  hzsel_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_ZONE(NUM_ZONE), .NUM_FAN(NUM_FAN),
    .TEMP_W(TEMP_W), .OFS_W(OFS_W), .NUM_OFS(NUM_OFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcTemp(srcTemp), .srcOffset(srcOffset), .zoneMap(zoneMap),
    .fanMask(fanMask), .srcReport(srcReport),
    .fanTemp(fanTemp), .fanZone(fanZone)
  );
endmodule

// File: rtl/hotzone_fan_sel_chk.sv
module hotzone_fan_sel_chk #(
  parameter int NUM_SRC  = 6,
  parameter int NUM_ZONE = 4,
  parameter int NUM_FAN  = 3,
  parameter int TEMP_W   = 16,
  parameter int OFS_W    = 8,
  parameter int NUM_OFS  = 2
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic                                  sampleEn,
  input logic [NUM_SRC*TEMP_W-1:0]             srcTemp,
  input logic [NUM_OFS*OFS_W-1:0]              srcOffset,
  input logic [NUM_FAN*NUM_ZONE-1:0]           fanMask,
  input logic [NUM_SRC*TEMP_W-1:0]             srcReport,
  input logic [NUM_FAN*TEMP_W-1:0]             fanTemp,
  input logic [NUM_FAN*$clog2(NUM_ZONE+1)-1:0] fanZone
);
  localparam int ZIDX_W = $clog2(NUM_ZONE+1);
  localparam logic [TEMP_W-1:0] T_MIN   = {1'b1, {(TEMP_W-1){1'b0}}};
  localparam logic [ZIDX_W-1:0] NO_ZONE = '1;

  logic [1:0] rstCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstCnt <= '0;
    else if (rstCnt != 2'd3) rstCnt <= rstCnt + 2'd1;
  end

  for (genvar f = 0; f < NUM_FAN; f++) begin : g_fanChk
    AST_FAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (rstCnt == 2'd3 && !$past(sampleEn, 2)) |->
        ($stable(fanTemp[f*TEMP_W +: TEMP_W]) && $stable(fanZone[f*ZIDX_W +: ZIDX_W]))); // R10
    AST_ZONE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      (fanZone[f*ZIDX_W +: ZIDX_W] != NO_ZONE) |->
        (int'(fanZone[f*ZIDX_W +: ZIDX_W]) < NUM_ZONE)); // R8
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rstN)
      (rstCnt == 2'd3 && $past(sampleEn, 2) && $past(fanMask[f*NUM_ZONE +: NUM_ZONE]) == '0) |->
        (fanZone[f*ZIDX_W +: ZIDX_W] == NO_ZONE && fanTemp[f*TEMP_W +: TEMP_W] == T_MIN)); // R9
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_srcChk
    if (s < NUM_OFS) begin : g_ofs
      AST_ZERO_OFS_PASS: assert property (@(posedge clk) disable iff (!rstN)
        (rstCnt != 2'd0 && $past(sampleEn) && $past(srcOffset[s*OFS_W +: OFS_W]) == '0) |->
          (srcReport[s*TEMP_W +: TEMP_W] == $past(srcTemp[s*TEMP_W +: TEMP_W]))); // R4
    end else begin : g_pass
      AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rstN)
        (rstCnt != 2'd0 && $past(sampleEn)) |->
          (srcReport[s*TEMP_W +: TEMP_W] == $past(srcTemp[s*TEMP_W +: TEMP_W]))); // R4
    end
    AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (rstCnt != 2'd0 && !$past(sampleEn)) |-> $stable(srcReport[s*TEMP_W +: TEMP_W])); // R10
  end
endmodule

bind hotzone_fan_sel hotzone_fan_sel_chk #(
  .NUM_SRC(NUM_SRC), .NUM_ZONE(NUM_ZONE), .NUM_FAN(NUM_FAN),
  .TEMP_W(TEMP_W), .OFS_W(OFS_W), .NUM_OFS(NUM_OFS)
) chk_i (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .srcTemp(srcTemp),
  .srcOffset(srcOffset), .fanMask(fanMask), .srcReport(srcReport),
  .fanTemp(fanTemp), .fanZone(fanZone)
);

// File: tb/hotzone_fan_sel_tb.sv
`timescale 1ns/1ps
module hotzone_fan_sel_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b0;
  logic [95:0] srcTemp = '0;
  logic [15:0] srcOffset = '0;
  logic        mapWe = 1'b0;
  logic [2:0]  mapSel = '0;
  logic [1:0]  mapZone = '0;
  logic [11:0] fanMask = '0;
  logic [95:0] srcReport;
  logic [47:0] fanTemp;
  logic [8:0]  fanZone;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hotzone_fan_sel dut_i (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .srcTemp(srcTemp),
    .srcOffset(srcOffset), .mapWe(mapWe), .mapSel(mapSel), .mapZone(mapZone),
    .fanMask(fanMask), .srcReport(srcReport), .fanTemp(fanTemp), .fanZone(fanZone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rep(input int s); return srcReport[s*16 +: 16]; endfunction
  function automatic logic [15:0] ft(input int f);  return fanTemp[f*16 +: 16];   endfunction
  function automatic logic [2:0]  fz(input int f);  return fanZone[f*3 +: 3];     endfunction

  task automatic setSrc(input logic [15:0] t0, t1, t2, t3, t4, t5);
    srcTemp = {t5, t4, t3, t2, t1, t0};
  endtask

  // pulse sampleEn and wait until fan outputs are valid
  task automatic sampleAll();
    @(negedge clk) sampleEn = 1'b1;
    @(negedge clk) sampleEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeMap(input int s, input int z);
    @(negedge clk);
    mapWe = 1'b1; mapSel = 3'(s); mapZone = 2'(z);
    @(negedge clk) mapWe = 1'b0;
  endtask

  task automatic testReset();
    for (int f = 0; f < 3; f++) begin
      chk("R1 fanTemp", 32'(ft(f)), 32'h8000);
      chk("R1 fanZone", 32'(fz(f)), 32'h7);
    end
    chk("R1 srcReport", 32'(srcReport[31:0]), 32'h0);
  endtask

  task automatic testDefaultMap();
    srcOffset = '0;
    setSrc(16'h1000, 16'h2000, 16'h3000, 16'h0500, 16'h1800, 16'h0100);
    fanMask = {4'b1111, 4'b1010, 4'b0001};
    sampleAll();
    chk("R2 R6 fan0 temp", 32'(ft(0)), 32'h1800);
    chk("R2 fan0 zone", 32'(fz(0)), 32'h0);
    chk("R7 fan1 temp", 32'(ft(1)), 32'h2000);
    chk("R7 fan1 zone", 32'(fz(1)), 32'h1);
    chk("R7 fan2 temp", 32'(ft(2)), 32'h3000);
    chk("R8 fan2 zone", 32'(fz(2)), 32'h2);
  endtask

  task automatic testTieAndEmpty();
    setSrc(16'h1000, 16'h2000, 16'h2000, 16'h0500, 16'h1800, 16'h0100);
    fanMask = {4'b0110, 4'b1000, 4'b0000};
    sampleAll();
    chk("R8 tie temp", 32'(ft(2)), 32'h2000);
    chk("R8 tie lower zone", 32'(fz(2)), 32'h1);
    chk("R9 empty temp", 32'(ft(0)), 32'h8000);
    chk("R9 empty code", 32'(fz(0)), 32'h7);
    chk("R7 single zone", 32'(ft(1)), 32'h0500);
  endtask

  task automatic testOffsets();
    setSrc(16'h1000, 16'h2000, 16'h0300, 16'h0400, 16'h0100, 16'h0100);
    srcOffset = {8'hFF, 8'h10};
    fanMask = {4'b0000, 4'b0010, 4'b0001};
    sampleAll();
    chk("R4 report s0", 32'(rep(0)), 32'h1010);
    chk("R4 report s1", 32'(rep(1)), 32'h1FFF);
    chk("R4 report s3 unchanged", 32'(rep(3)), 32'h0400);
    chk("R4 control s0", 32'(ft(0)), 32'h1010);
    chk("R4 control s1", 32'(ft(1)), 32'h1FFF);
  endtask

  task automatic testSaturation();
    setSrc(16'h7FF0, 16'h8005, 16'h0300, 16'h0400, 16'h0100, 16'h0100);
    srcOffset = {8'h80, 8'h7F};
    fanMask = {4'b0000, 4'b0010, 4'b0001};
    sampleAll();
    chk("R5 high clamp", 32'(rep(0)), 32'h7FFF);
    chk("R5 low clamp", 32'(rep(1)), 32'h8000);
    chk("R5 clamp control", 32'(ft(0)), 32'h7FFF);
  endtask

  task automatic testTiming();
    srcOffset = '0;
    setSrc(16'h0A00, 16'h0200, 16'h0300, 16'h0400, 16'h0B00, 16'h0100);
    fanMask = {4'b0000, 4'b0000, 4'b0001};
    repeat (3) @(negedge clk);
    chk("R10 report holds", 32'(rep(0)), 32'h7FFF);
    chk("R10 fan holds", 32'(ft(0)), 32'h7FFF);
    @(negedge clk) sampleEn = 1'b1;
    @(negedge clk) sampleEn = 1'b0;
    chk("R10 report after one edge", 32'(rep(0)), 32'h0A00);
    chk("R10 fan not yet", 32'(ft(0)), 32'h7FFF);
    @(negedge clk);
    chk("R10 fan after two edges", 32'(ft(0)), 32'h0B00);
  endtask

  task automatic testRemap();
    setSrc(16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0050, 16'h0600);
    fanMask = {4'b0011, 4'b0100, 4'b1000};
    writeMap(5, 3);
    writeMap(0, 2);
    writeMap(1, 2);
    writeMap(3, 2);
    writeMap(7, 0);
    chk("R3 write alone no effect", 32'(ft(0)), 32'h0B00);
    sampleAll();
    chk("R3 remapped fan0 temp", 32'(ft(0)), 32'h0600);
    chk("R3 remapped fan0 zone", 32'(fz(0)), 32'h3);
    chk("R6 four sources in zone", 32'(ft(1)), 32'h0400);
    chk("R6 empty zone loses", 32'(ft(2)), 32'h0050);
    chk("R6 empty zone index", 32'(fz(2)), 32'h0);
  endtask

  task automatic testResolution();
    setSrc(16'h1234, 16'h1235, 16'hFF00, 16'h1233, 16'h0010, 16'hF000);
    fanMask = {4'b0010, 4'b0100, 4'b1001};
    sampleAll();
    chk("R11 LSB resolved", 32'(ft(1)), 32'h1235);
    chk("R7 signed max", 32'(ft(0)), 32'h0010);
    chk("R7 signed zone", 32'(fz(0)), 32'h0);
    chk("R6 empty zone alone", 32'(ft(2)), 32'h8000);
    chk("R6 empty zone alone idx", 32'(fz(2)), 32'h1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDefaultMap();
    testTieAndEmpty();
    testOffsets();
    testSaturation();
    testTiming();
    testRemap();
    testResolution();
    finishRun();
  end
endmodule